// File: doc/BRIEF.md
# Multiplexed Host Bus Register Interface

This block lets a host processor read and write a small bank of eight byte-wide registers over one of three parallel bus styles. In the multiplexed style, the address and the data share one 8-bit bus. An address-latch strobe marks the address phase. In the two non-multiplexed styles, a small address bus is used. The latch pin then carries the lowest address bit. In all styles, chip select qualifies active-low read and write strobes.

Two static pins pick the style. The same choice also sets the polarity of the host reset pin and the way the interrupt pin is driven. Every host-side pin is synchronized into the system clock domain before it is used. Each strobe must stay asserted for a minimum number of system clocks before the block accepts it. The host reset pin must likewise stay asserted for a minimum number of clocks before it clears the register bank. During a host reset, the serial transmit output is forced to idle high.

Top module: `host_bus_if`

## Requirements
- R1: With `mux_en_i`=1 the multiplexed style is used and `intel_sel_i` has no effect. With `mux_en_i`=0, `intel_sel_i`=1 selects the Intel style and `intel_sel_i`=0 selects the Motorola style.
- R2: In the multiplexed style, the address is taken from `ad_i[7:0]` when `ale_n_i` returns high after a low period. That address is used by all following reads and writes until the next latch.
- R3: In the Intel and Motorola styles, the register address is {`addr_hi_i[1:0]`, `ale_n_i`}. The latch pin serves as address bit 0.
- R4: When `wr_n_i` returns high with `cs_n_i` low, the byte on `ad_i` is stored in the addressed register.
- R5: A low period of `wr_n_i`, `rd_n_i` or `ale_n_i` is ignored when it is shorter than 3 system clocks. A low period of exactly 3 clocks is accepted.
- R6: A write strobe is ignored while `cs_n_i` is high.
- R7: `ad_oe_o` is high only while both `cs_n_i` and `rd_n_i` are low, and then `ad_o` carries the addressed register. When `ad_oe_o` is low, `ad_o` is zero.
- R8: In the multiplexed style, addresses 8 to 255 are unimplemented. A write to one of them changes no register, and a read from one of them returns 0.
- R9: `bus_rst_i` is active high in the Intel and multiplexed styles and active low in the Motorola style. An assertion of 1 clock is ignored. An assertion of 2 or more clocks clears every register to 0.
- R10: `txd_o` is 1 while a host reset is in effect or `rst_ni` is low. Otherwise `txd_o` follows `tx_bit_i`.
- R11: In the Intel and multiplexed styles, `irq_o` follows `irq_req_i` and `irq_oe_o` equals bit 3 of register 4. In the Motorola style, `irq_o` is 0 and `irq_oe_o` follows `irq_req_i`, so the pin behaves as open drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| mux_en_i | input | 1 | Multiplexed-style enable (static) |
| intel_sel_i | input | 1 | Intel (1) or Motorola (0) style select (static) |
| bus_rst_i | input | 1 | Host reset pin, polarity set by the style |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ale_n_i | input | 1 | Address latch strobe, or address bit 0 in the non-multiplexed styles |
| addr_hi_i | input | 2 | Address bits 2:1 in the non-multiplexed styles |
| ad_i | input | 8 | Address/data bus, input side |
| ad_o | output | 8 | Read data bus, output side |
| ad_oe_o | output | 1 | Data bus output enable |
| irq_req_i | input | 1 | Interrupt request from the peripheral |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin drive enable |
| tx_bit_i | input | 1 | Serial transmit bit from the peripheral |
| txd_o | output | 1 | Serial transmit output |

## Verification
The hardest cases to reach are the pulse-width boundaries. A strobe held for 2 clocks must be dropped, and one held for 3 clocks must be taken. A host reset of 1 clock must leave the registers intact, and one of 2 clocks must clear them. The bench drives these pulses on falling clock edges, so each one maps to an exact count of synchronized cycles. It then reads the registers back to show what a short pulse left untouched. A second hard case is a change of style between Motorola and another style. That change must not create a false host reset, so the bench flips the style and the reset pin level together and then confirms that the stored data survived.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    STYLE_INTEL = 2'd0,
    STYLE_MOTO  = 2'd1,
    STYLE_MUX   = 2'd2
  } bus_style_e;

  function automatic bus_style_e pick_style(input logic mux_en, input logic intel_sel);
    if (mux_en) return STYLE_MUX;
    return intel_sel ? STYLE_INTEL : STYLE_MOTO;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hbi_pulse_qual.sv
module hbi_pulse_qual #(
  parameter int MIN_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic level_o,
  output logic end_o
);
  localparam int CNT_W = $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_W);
  localparam logic [CNT_W-1:0] LVL_T   = CNT_W'(MIN_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!act_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // level: MIN_W-th consecutive active cycle or later; end: release after a long enough pulse
  assign level_o = act_i && (cnt_q >= LVL_T);
  assign end_o   = !act_i && (cnt_q >= CNT_MAX);

  AST_END_AFTER_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> $past(act_i)); // R5
  AST_LEVEL_NEEDS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o && LVL_T != 0) |-> $past(act_i)); // R5
endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int BUS_W    = 8,
  parameter int CTRL_IDX = 4,
  parameter int IEN_BIT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ien_o
);
  localparam int NUM = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NUM];
  logic              hit;
  logic [ADDR_W-1:0] idx;

  assign hit = ({1'b0, addr_i} < (BUS_W+1)'(NUM));
  assign idx = addr_i[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
    end else if (we_i && hit) begin
      regs_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = hit ? regs_q[idx] : '0;
  assign ien_o   = regs_q[CTRL_IDX][IEN_BIT];

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == '0 && !ien_o)); // R9
  AST_UNIMPL_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit && !clr_i) |=> (ien_o == $past(ien_o))); // R8
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int BUS_W   = 8,
  parameter int STB_MIN = 3,
  parameter int RST_MIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_en_i,
  input  logic              intel_sel_i,
  input  logic              bus_rst_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              ale_n_i,
  input  logic [ADDR_W-2:0] addr_hi_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              irq_oe_o,
  input  logic              tx_bit_i,
  output logic              txd_o
);
  localparam int NSTB    = 3;  // 0: read, 1: write, 2: address latch
  localparam int STB_RD  = 0;
  localparam int STB_WR  = 1;
  localparam int STB_ALE = 2;

  bus_style_e style;
  assign style = pick_style(mux_en_i, intel_sel_i);

  // strobe and data synchronizers
  logic [3:0]              ctl_s;
  logic                    cs_s_n, rd_s_n, wr_s_n, ale_s_n;
  logic [BUS_W+ADDR_W-2:0] dat_s;
  logic [BUS_W-1:0]        ad_s;
  logic [ADDR_W-2:0]       ahi_s;
  logic                    rst_raw, rst_act;

  hbi_sync #(.W(4), .RST_VAL(4'hF)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({cs_n_i, rd_n_i, wr_n_i, ale_n_i}), .q_o(ctl_s));
  assign {cs_s_n, rd_s_n, wr_s_n, ale_s_n} = ctl_s;

  hbi_sync #(.W(BUS_W+ADDR_W-1), .RST_VAL('0)) u_sync_dat (
    .clk_i, .rst_ni, .d_i({ad_i, addr_hi_i}), .q_o(dat_s));
  assign {ad_s, ahi_s} = dat_s;

  // polarity applied before sync so a style change with the pin cannot glitch
  assign rst_raw = (style == STYLE_MOTO) ? !bus_rst_i : bus_rst_i;
  hbi_sync #(.W(1), .RST_VAL(1'b0)) u_sync_rst (
    .clk_i, .rst_ni, .d_i(rst_raw), .q_o(rst_act));

  // strobe qualification
  logic [NSTB-1:0] stb_act, stb_lvl, stb_end;
  assign stb_act = {!ale_s_n, !wr_s_n, !rd_s_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    hbi_pulse_qual #(.MIN_W(STB_MIN)) u_qual (
      .clk_i, .rst_ni, .act_i(stb_act[g]), .level_o(stb_lvl[g]), .end_o(stb_end[g]));
  end

  logic soft_rst, rst_end;
  hbi_pulse_qual #(.MIN_W(RST_MIN)) u_rst_qual (
    .clk_i, .rst_ni, .act_i(rst_act), .level_o(soft_rst), .end_o(rst_end));

  // address path
  logic [BUS_W-1:0] lat_addr_q, eff_addr;
  logic             cs_act;
  assign cs_act = !cs_s_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      lat_addr_q <= '0;
    else if (soft_rst)                                lat_addr_q <= '0;
    else if (style == STYLE_MUX && stb_end[STB_ALE])  lat_addr_q <= ad_s;
  end

  assign eff_addr = (style == STYLE_MUX) ? lat_addr_q
                  : {{(BUS_W-ADDR_W){1'b0}}, ahi_s, ale_s_n};

  // register bank
  logic             wr_commit, ien;
  logic [BUS_W-1:0] rd_byte;
  assign wr_commit = stb_end[STB_WR] && cs_act && !soft_rst;

  hbi_regbank #(.ADDR_W(ADDR_W), .DATA_W(BUS_W), .BUS_W(BUS_W), .CTRL_IDX(4), .IEN_BIT(3)) u_bank (
    .clk_i, .rst_ni, .clr_i(soft_rst), .we_i(wr_commit), .addr_i(eff_addr),
    .wdata_i(ad_s), .rdata_o(rd_byte), .ien_o(ien));

  // read path
  logic rd_go;
  assign rd_go = stb_lvl[STB_RD] && cs_act && !soft_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ad_oe_o <= 1'b0;
      ad_o    <= '0;
    end else begin
      ad_oe_o <= rd_go;
      ad_o    <= rd_go ? rd_byte : '0;
    end
  end

  // interrupt and transmit pins
  always_comb begin
    if (style == STYLE_MOTO) begin
      irq_o    = 1'b0;
      irq_oe_o = irq_req_i && !soft_rst && rst_ni;
    end else begin
      irq_o    = irq_req_i;
      irq_oe_o = ien;
    end
  end

  assign txd_o = (!rst_ni || soft_rst) ? 1'b1 : tx_bit_i;

  logic unused_sig;
  assign unused_sig = ^{stb_end[STB_RD], stb_lvl[STB_WR], stb_lvl[STB_ALE], rst_end};

  AST_OE_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> (ad_o == '0)); // R7
  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(cs_act && !rd_s_n)); // R7
  AST_NO_WRITE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> !ad_oe_o); // R9
  AST_MOTO_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style == STYLE_MOTO && irq_oe_o) |-> !irq_o); // R11
  AST_TXD_IDLE_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |-> txd_o); // R10
endmodule

// File: tb/host_bus_if_test.sv
module host_bus_if_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mux_en = 1'b0, intel_sel = 1'b1, bus_rst = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ale_n = 1'b1;
  logic [1:0] a_hi = '0;
  logic [7:0] ad_in = '0, ad_out;
  logic ad_oe, irq_req = 1'b0, irq, irq_oe, tx_bit = 1'b0, txd;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #(CLK_P/2) clk = ~clk;

  host_bus_if uut (
    .clk_i(clk), .rst_ni, .mux_en_i(mux_en), .intel_sel_i(intel_sel), .bus_rst_i(bus_rst),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .ale_n_i(ale_n), .addr_hi_i(a_hi),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe), .irq_req_i(irq_req), .irq_o(irq),
    .irq_oe_o(irq_oe), .tx_bit_i(tx_bit), .txd_o(txd));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (mux_en && a >= 8) return 8'h00;
    return model[a[2:0]];
  endfunction

  task automatic set_addr(input logic [7:0] a, input int w = 4);
    if (mux_en) begin
      ad_in = a; ale_n = 1'b0; cyc(w);
      ale_n = 1'b1; cyc(2);
    end else begin
      a_hi = a[2:1]; ale_n = a[0]; cyc(1);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                          input int w = 4, input bit use_cs = 1'b1);
    set_addr(a);
    ad_in = d; cs_n = !use_cs; cyc(1);
    wr_n = 1'b0; cyc(w);
    wr_n = 1'b1; cyc(1);
    cs_n = 1'b1; cyc(4);
    if (use_cs && w >= 3 && !(mux_en && a >= 8)) model[a[2:0]] = d;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic oe,
                         input bit addr_set = 1'b1);
    if (addr_set) set_addr(a);
    ad_in = 8'h00; cs_n = 1'b0; cyc(1);
    rd_n = 1'b0; cyc(6);
    d = ad_out; oe = ad_oe;
    rd_n = 1'b1; cyc(1);
    cs_n = 1'b1; cyc(4);
  endtask

  task automatic check_reg(input logic [7:0] a, input string req);
    logic [7:0] d; logic oe;
    do_read(a, d, oe);
    chk(oe === 1'b1 && d === exp_rd(a), req, d, exp_rd(a));
  endtask

  task automatic host_reset(input int n);
    logic act;
    act = (!mux_en && !intel_sel) ? 1'b0 : 1'b1;
    bus_rst = act; cyc(n);
    bus_rst = !act; cyc(4);
    if (n >= 2) for (int i = 0; i < 8; i++) model[i] = 8'h00;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a;
    logic oe;
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;

    cyc(2);
    chk(txd === 1'b1, "R10 txd in system reset", txd, 1);
    chk(ad_oe === 1'b0 && ad_out === 8'h00, "R7 bus idle in reset", ad_oe, 0);
    rst_ni = 1'b1; cyc(4);
    chk(irq_oe === 1'b0, "R11 irq off after reset", irq_oe, 0);
    check_reg(8'd5, "R7 reset value");

    // Intel, non-multiplexed
    for (int i = 0; i < 8; i++) do_write(8'(i), 8'($urandom), 4);
    for (int i = 0; i < 8; i++) check_reg(8'(i), "R3 R4 intel address");
    chk(ad_oe === 1'b0 && ad_out === 8'h00, "R7 oe low after read", ad_oe, 0);

    do_write(8'd2, 8'hA5, 2);
    check_reg(8'd2, "R5 two-cycle write ignored");
    do_write(8'd2, 8'h3C, 3);
    check_reg(8'd2, "R5 three-cycle write accepted");
    do_write(8'd6, 8'h77, 5, 1'b0);
    check_reg(8'd6, "R6 write without cs ignored");

    // short read strobe must never raise oe
    set_addr(8'd1);
    cs_n = 1'b0; cyc(1);
    rd_n = 1'b0; cyc(2); rd_n = 1'b1;
    oe = 1'b0;
    for (int i = 0; i < 6; i++) begin cyc(1); oe = oe | ad_oe; end
    cs_n = 1'b1; cyc(2);
    chk(oe === 1'b0, "R5 R7 short read ignored", oe, 0);

    // read without cs
    set_addr(8'd1);
    rd_n = 1'b0; cyc(6); oe = ad_oe; rd_n = 1'b1; cyc(3);
    chk(oe === 1'b0, "R7 read without cs", oe, 0);

    // interrupt, Intel style
    irq_req = 1'b1;
    do_write(8'd4, 8'h08);
    chk(irq_oe === 1'b1 && irq === 1'b1, "R11 intel irq enabled", {irq_oe, irq}, 3);
    do_write(8'd4, 8'h00);
    chk(irq_oe === 1'b0, "R11 intel irq tri-state", irq_oe, 0);
    irq_req = 1'b0;

    tx_bit = 1'b0; cyc(1);
    chk(txd === 1'b0, "R10 txd follows bit", txd, 0);
    tx_bit = 1'b1; cyc(1);
    chk(txd === 1'b1, "R10 txd follows bit high", txd, 1);
    tx_bit = 1'b0;

    host_reset(1);
    check_reg(8'd3, "R9 intel 1-cycle reset ignored");
    bus_rst = 1'b1; cyc(3);
    chk(txd === 1'b1, "R10 txd idle in host reset", txd, 1);
    bus_rst = 1'b0; cyc(4);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    check_reg(8'd3, "R9 intel 2+ cycle reset clears");

    // multiplexed style
    ale_n = 1'b1; cyc(3);
    mux_en = 1'b1; cyc(3);
    for (int i = 0; i < 30; i++) begin
      a = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else check_reg(a, "R2 R4 mux random");
    end
    intel_sel = 1'b0; cyc(6);
    chk(txd === 1'b1 || tx_bit == 1'b0, "R1 style stays mux", txd, 0);
    check_reg(8'd0, "R1 mux ignores intel select");
    check_reg(8'd7, "R1 mux ignores intel select");

    do_write(8'h1A, 8'hEE);
    check_reg(8'h1A, "R8 unimplemented read zero");
    check_reg(8'd2, "R8 unimplemented write no effect");

    do_write(8'd3, 8'h5A);
    set_addr(8'd3);
    set_addr(8'd5, 2);  // short latch must keep address 3
    ad_in = 8'hC3; cs_n = 1'b0; cyc(1); wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(1); cs_n = 1'b1; cyc(4);
    model[3] = 8'hC3;
    check_reg(8'd3, "R5 R2 short latch ignored");
    check_reg(8'd5, "R5 R2 short latch ignored");

    do_read(8'd0, d, oe, 1'b0);
    chk(oe === 1'b1 && d === model[5], "R2 latched address reused", d, model[5]);

    // Motorola style: flip style and reset pin together
    mux_en = 1'b0; bus_rst = 1'b1; cyc(6);
    for (int i = 0; i < 8; i++) check_reg(8'(i), "R1 R3 motorola no false reset");

    irq_req = 1'b1; cyc(1);
    chk(irq_oe === 1'b1 && irq === 1'b0, "R11 motorola drives low", {irq_oe, irq}, 2);
    irq_req = 1'b0; cyc(1);
    chk(irq_oe === 1'b0, "R11 motorola released", irq_oe, 0);

    host_reset(1);
    check_reg(8'd6, "R9 motorola 1-cycle reset ignored");
    bus_rst = 1'b0; cyc(4);
    chk(txd === 1'b1, "R10 txd idle motorola reset", txd, 1);
    bus_rst = 1'b1; cyc(4);
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    check_reg(8'd6, "R9 motorola reset clears");

    for (int i = 0; i < 20; i++) begin
      a = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom), $urandom_range(3, 5));
      else check_reg(a, "R4 R7 motorola random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule